// File: doc/BRIEF.md
# DAC Deferred-Update Trigger Controller

This block sits between a byte-wide register write port and the input latch of a 10-bit current DAC. Software writes a control byte and two data bytes. The data bytes land in staging registers. The DAC input latch copies them only when a selected update event fires. The event can be an overflow pulse from one of four timers, or a rising, falling or either edge of an asynchronous conversion-start strobe. A further mode loads the latch directly on a write of the high byte.

The control byte also holds three other fields. An enable bit gates the output word. A retention bit decides whether a non-power-on reset clears the block. A range code is passed straight through to the analog section. Two resets come in: a power-on/supply-monitor reset that always clears everything, and a general system reset whose effect depends on the retention bit. The staged registers and the control byte are always visible on output ports.

Top module: `dac_update_ctrl`

## Requirements
- R1: Write addresses are 0 = control, 1 = high data, 2 = low data. Control bit 7 is enable, bits [6:4] are the update mode, bit 3 is retain, bit 2 reads as 0 and bits [1:0] are the range. After reset the control byte reads 0x02.
- R2: Mode codes 0 to 3 each load the latch on a pulse of `tmr_ovf[k]`, where k is the mode code. Pulses on any other timer line have no effect on the latch.
- R3: Mode codes 4, 5 and 6 load the latch on a rising edge, a falling edge, and either edge of `strobe_i`, in that order. The strobe passes through two synchronizer flops, so the latch shows the new word after the third rising clock edge following the strobe change, and not after the second.
- R4: In modes 0 to 6, writes to the data registers change only the staged bytes. `dac_code_o` stays unchanged until the selected event occurs.
- R5: The latched word is left-justified. Output bits 9..2 take high-byte bits 7..0, and output bits 1..0 take low-byte bits 7..6.
- R6: If a data write and an update event fall in the same cycle, the latch takes the staged word from before that write. The new byte waits for the next event.
- R7: Mode code 7 loads the latch in the same cycle as a write to the high byte. The loaded word is the newly written high byte together with the current low byte.
- R8: Power-on reset, and system reset while retain is 0, return control to 0x02, clear both staged bytes and clear the latch.
- R9: While retain is 1, a system reset leaves the control byte, the staged bytes and the latched word unchanged.
- R10: `range_o` follows control bits [1:0]. Its reset value is 2'b10, the largest full scale.
- R11: While enable is 0, `dac_code_o` reads 0. The latch still updates on events, and the staged bytes stay readable on `hi_o` and `lo_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por_n | input | 1 | Power-on / supply-monitor reset, asynchronous, active low |
| rst_sys_n | input | 1 | General system reset, synchronous, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 high, 2 low) |
| wr_data | input | 8 | Write data byte |
| tmr_ovf | input | 4 | Timer overflow pulses |
| strobe_i | input | 1 | Asynchronous conversion-start strobe |
| ctrl_o | output | 8 | Control byte readback |
| hi_o | output | 8 | Staged high byte |
| lo_o | output | 8 | Staged low byte |
| dac_en_o | output | 1 | DAC enable |
| range_o | output | 2 | Full-scale range code |
| dac_code_o | output | 10 | Latched DAC word, zero when disabled |

## Verification
The hardest situation to reach is a data write and its update event landing on the same clock edge. Random traffic hits it only by chance. Directed ticks therefore pair a high-byte write with the matching timer pulse, and the latch is expected to take the older staged word. The strobe edge paths are hard in a different way: the outcome depends on counting synchronizer stages. So the bench changes the strobe at a known falling clock edge and samples both one edge before the load and at the load. Retention under system reset is reached only after a control write with retain set, followed by a reset pulse and then a power-on reset.

// File: rtl/dac_upd_pkg.sv
package dac_upd_pkg;
    localparam int BYTE_W = 8;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_HI   = 2'd1;
    localparam logic [1:0] ADDR_LO   = 2'd2;

    localparam logic [2:0] MODE_RISE = 3'd4;
    localparam logic [2:0] MODE_FALL = 3'd5;
    localparam logic [2:0] MODE_BOTH = 3'd6;
    localparam logic [2:0] MODE_IMM  = 3'd7;

    typedef struct packed {
        logic       en;
        logic [2:0] mode;
        logic       retain;
        logic [1:0] range;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{en: 1'b0, mode: 3'd0, retain: 1'b0, range: 2'b10};
endpackage

// File: rtl/dac_strobe_sync.sv
module dac_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], strobe_i};
        prev_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign rise_o =  sync_q[STAGES-1] & ~prev_q;
    assign fall_o = ~sync_q[STAGES-1] &  prev_q;
endmodule

// File: rtl/dac_event_sel.sv
module dac_event_sel
    import dac_upd_pkg::*;
#(
    parameter int NUM_TMR = 4
) (
    input  logic [2:0]         mode,
    input  logic [NUM_TMR-1:0] tmr_ovf,
    input  logic               str_rise,
    input  logic               str_fall,
    input  logic               hi_write,
    output logic               evt_o
);
    logic [NUM_TMR-1:0] tmr_hit;

    for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
        assign tmr_hit[k] = (mode == 3'(k)) && tmr_ovf[k];
    end

    always_comb begin
        case (mode)
            MODE_RISE: evt_o = str_rise;
            MODE_FALL: evt_o = str_fall;
            MODE_BOTH: evt_o = str_rise | str_fall;
            MODE_IMM:  evt_o = hi_write;
            default:   evt_o = |tmr_hit;
        endcase
    end
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
    import dac_upd_pkg::*;
#(
    parameter int DAC_W       = 10,
    parameter int NUM_TMR     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_por_n,
    input  logic               rst_sys_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [NUM_TMR-1:0] tmr_ovf,
    input  logic               strobe_i,
    output logic [7:0]         ctrl_o,
    output logic [7:0]         hi_o,
    output logic [7:0]         lo_o,
    output logic               dac_en_o,
    output logic [1:0]         range_o,
    output logic [DAC_W-1:0]   dac_code_o
);
    localparam int LO_BITS = DAC_W - BYTE_W;

    typedef struct packed {
        ctrl_t              ctrl;
        logic [BYTE_W-1:0]  hi;
        logic [BYTE_W-1:0]  lo;
        logic [DAC_W-1:0]   latch;
    } state_t;

    state_t st_d, st_q;
    logic   str_rise, str_fall, hi_write, upd_evt;
    logic [DAC_W-1:0] latch_w;

    dac_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_por_n),
        .strobe_i (strobe_i),
        .rise_o   (str_rise),
        .fall_o   (str_fall)
    );

    assign hi_write = wr_en && (wr_addr == ADDR_HI);

    dac_event_sel #(.NUM_TMR(NUM_TMR)) u_evt (
        .mode     (st_q.ctrl.mode),
        .tmr_ovf  (tmr_ovf),
        .str_rise (str_rise),
        .str_fall (str_fall),
        .hi_write (hi_write),
        .evt_o    (upd_evt)
    );

    always_comb begin
        st_d = st_q;
        if (!rst_sys_n) begin
            if (!st_q.ctrl.retain) begin
                st_d.ctrl  = CTRL_RST;
                st_d.hi    = '0;
                st_d.lo    = '0;
                st_d.latch = '0;
            end
        end else begin
            if (upd_evt) begin
                if (st_q.ctrl.mode == MODE_IMM)
                    st_d.latch = {wr_data, st_q.lo[BYTE_W-1 -: LO_BITS]};
                else
                    st_d.latch = {st_q.hi, st_q.lo[BYTE_W-1 -: LO_BITS]};
            end
            if (wr_en) begin
                case (wr_addr)
                    ADDR_CTRL: st_d.ctrl = ctrl_t'({wr_data[7:3], wr_data[1:0]});
                    ADDR_HI:   st_d.hi   = wr_data;
                    ADDR_LO:   st_d.lo   = wr_data;
                    default:   ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_por_n) begin
        if (!rst_por_n) begin
            st_q <= '{ctrl: CTRL_RST, hi: '0, lo: '0, latch: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign latch_w    = st_q.latch;
    assign ctrl_o     = {st_q.ctrl.en, st_q.ctrl.mode, st_q.ctrl.retain, 1'b0, st_q.ctrl.range};
    assign hi_o       = st_q.hi;
    assign lo_o       = st_q.lo;
    assign dac_en_o   = st_q.ctrl.en;
    assign range_o    = st_q.ctrl.range;
    assign dac_code_o = st_q.ctrl.en ? st_q.latch : '0;
endmodule

// File: rtl/dac_update_ctrl_chk.sv
module dac_update_ctrl_chk #(
    parameter int DAC_W = 10
) (
    input logic             clk,
    input logic             rst_por_n,
    input logic             rst_sys_n,
    input logic             upd_evt,
    input logic             str_rise,
    input logic             str_fall,
    input logic [7:0]       ctrl,
    input logic [7:0]       hi,
    input logic [7:0]       lo,
    input logic [DAC_W-1:0] latch,
    input logic [DAC_W-1:0] dac_code,
    input logic             dac_en
);
    localparam int LO_BITS = DAC_W - 8;

    AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_por_n)
        (rst_sys_n && !upd_evt) |=> $stable(latch)); // R4

    AST_LOAD_STAGED: assert property (@(posedge clk) disable iff (!rst_por_n)
        (rst_sys_n && upd_evt && ctrl[6:4] != 3'd7) |=> latch == $past({hi, lo[7 -: LO_BITS]})); // R6

    AST_IMM_LOAD: assert property (@(posedge clk) disable iff (!rst_por_n)
        (rst_sys_n && upd_evt && ctrl[6:4] == 3'd7) |=> latch[DAC_W-1 -: 8] == hi); // R7

    AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (!rst_por_n)
        str_rise |=> !str_rise); // R3

    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_por_n)
        !(str_rise && str_fall)); // R3

    AST_SYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_por_n)
        (!rst_sys_n && !ctrl[3]) |=> (dac_code == '0 && !dac_en && ctrl == 8'h02)); // R8

    AST_RETAIN_KEEP: assert property (@(posedge clk) disable iff (!rst_por_n)
        (!rst_sys_n && ctrl[3]) |=> ($stable(dac_code) && $stable(ctrl) && $stable(hi))); // R9
endmodule

bind dac_update_ctrl dac_update_ctrl_chk #(.DAC_W(DAC_W)) u_chk (
    .clk       (clk),
    .rst_por_n (rst_por_n),
    .rst_sys_n (rst_sys_n),
    .upd_evt   (upd_evt),
    .str_rise  (str_rise),
    .str_fall  (str_fall),
    .ctrl      (ctrl_o),
    .hi        (hi_o),
    .lo        (lo_o),
    .latch     (latch_w),
    .dac_code  (dac_code_o),
    .dac_en    (dac_en_o)
);

// File: tb/dac_update_ctrl_bench.sv
`timescale 1ns/1ps
module dac_update_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_por_n = 1'b0;
    logic       rst_sys_n = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] tmr_ovf = '0;
    logic       strobe_i = 1'b0;
    logic [7:0] ctrl_o, hi_o, lo_o;
    logic       dac_en_o;
    logic [1:0] range_o;
    logic [9:0] dac_code_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] m_ctrl, m_hi, m_lo;
    logic [9:0] m_latch;

    always #2 clk = ~clk;

    dac_update_ctrl u_dac_update_ctrl (
        .clk, .rst_por_n, .rst_sys_n, .wr_en, .wr_addr, .wr_data, .tmr_ovf,
        .strobe_i, .ctrl_o, .hi_o, .lo_o, .dac_en_o, .range_o, .dac_code_o
    );

    function automatic logic [9:0] map_word(input logic [7:0] h, input logic [7:0] l);
        return {h, l[7:6]};
    endfunction

    function automatic logic [9:0] exp_code();
        return m_ctrl[7] ? m_latch : 10'd0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ctrl = 8'h02; m_hi = '0; m_lo = '0; m_latch = '0;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " code"}, 32'(dac_code_o), 32'(exp_code()));
        chk({tag, " ctrl"}, 32'(ctrl_o), 32'(m_ctrl));
        chk({tag, " hi"},   32'(hi_o),   32'(m_hi));
        chk({tag, " lo"},   32'(lo_o),   32'(m_lo));
        chk({tag, " range R10"}, 32'(range_o), 32'(m_ctrl[1:0]));
    endtask

    // one clock: drive at negedge, update model at posedge, return at next negedge
    task automatic tick(input logic we, input logic [1:0] a, input logic [7:0] d, input logic [3:0] t);
        logic evt;
        logic [2:0] md;
        wr_en = we; wr_addr = a; wr_data = d; tmr_ovf = t;
        @(posedge clk);
        md  = m_ctrl[6:4];
        evt = 1'b0;
        if (md < 3'd4) evt = t[md[1:0]];
        else if (md == 3'd7) evt = we && a == 2'd1;
        if (evt) m_latch = (md == 3'd7) ? map_word(d, m_lo) : map_word(m_hi, m_lo);
        if (we) begin
            case (a)
                2'd0: m_ctrl = d & 8'hFB;
                2'd1: m_hi = d;
                2'd2: m_lo = d;
                default: ;
            endcase
        end
        @(negedge clk);
        wr_en = 1'b0; tmr_ovf = '0;
    endtask

    task automatic idle(); tick(1'b0, 2'd0, 8'h00, 4'h0); endtask

    task automatic sys_reset();
        rst_sys_n = 1'b0;
        @(posedge clk);
        if (!m_ctrl[3]) model_reset();
        @(negedge clk);
        rst_sys_n = 1'b1;
    endtask

    task automatic por_reset();
        rst_por_n = 1'b0;
        #1;
        model_reset();
        @(negedge clk);
        rst_por_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5eed_0a1c));
        model_reset();
        repeat (3) @(negedge clk);
        rst_por_n = 1'b1;
        @(negedge clk);
        check_all("R8 reset");
        chk("R1 ctrl reset", 32'(ctrl_o), 32'h02);
        chk("R10 range reset", 32'(range_o), 32'h2);

        // R2: mode 1, enabled; other timers ignored
        tick(1'b1, 2'd0, 8'h90, 4'h0);
        tick(1'b1, 2'd1, 8'hA5, 4'h0);
        tick(1'b1, 2'd2, 8'hC0, 4'h0);
        chk("R4 held before event", 32'(dac_code_o), 32'h0);
        tick(1'b0, 2'd0, 8'h00, 4'b1101);
        chk("R2 other timers ignored", 32'(dac_code_o), 32'h0);
        tick(1'b0, 2'd0, 8'h00, 4'b0010);
        chk("R5 left-justified", 32'(dac_code_o), 32'h297);
        check_all("R2 timer1 load");

        // R6: write and event same cycle
        tick(1'b1, 2'd1, 8'h3C, 4'b0010);
        chk("R6 collision keeps old", 32'(dac_code_o), 32'h297);
        tick(1'b0, 2'd0, 8'h00, 4'b0010);
        chk("R6 next event loads", 32'(dac_code_o), 32'(map_word(8'h3C, 8'hC0)));

        // R7: immediate mode
        tick(1'b1, 2'd0, 8'hF1, 4'h0);
        tick(1'b1, 2'd2, 8'h40, 4'h0);
        chk("R7 low write no load", 32'(dac_code_o), 32'(map_word(8'h3C, 8'hC0)));
        tick(1'b1, 2'd1, 8'h81, 4'h0);
        chk("R7 immediate load", 32'(dac_code_o), 32'h205);
        chk("R10 range follows", 32'(range_o), 32'h1);

        // R11: disabled output reads zero, latch still updates
        tick(1'b1, 2'd0, 8'h70, 4'h0);
        tick(1'b1, 2'd1, 8'hFF, 4'h0);
        chk("R11 disabled zero", 32'(dac_code_o), 32'h0);
        chk("R11 staged readable", 32'(hi_o), 32'hFF);
        tick(1'b1, 2'd0, 8'hF0, 4'h0);
        chk("R11 enable shows latch", 32'(dac_code_o), 32'h3FD);

        // R3: strobe edges
        tick(1'b1, 2'd0, 8'hC0, 4'h0);
        tick(1'b1, 2'd1, 8'h11, 4'h0);
        strobe_i = 1'b1;
        idle(); idle();
        chk("R3 rise not after 2 edges", 32'(dac_code_o), 32'h3FD);
        idle(); m_latch = map_word(m_hi, m_lo);
        chk("R3 rise after 3 edges", 32'(dac_code_o), 32'h045);
        tick(1'b1, 2'd1, 8'h22, 4'h0);
        strobe_i = 1'b0;
        repeat (4) idle();
        chk("R3 rise mode ignores fall", 32'(dac_code_o), 32'h045);
        tick(1'b1, 2'd0, 8'hD0, 4'h0);
        strobe_i = 1'b1;
        repeat (4) idle();
        chk("R3 fall mode ignores rise", 32'(dac_code_o), 32'h045);
        strobe_i = 1'b0;
        idle(); idle(); idle(); m_latch = map_word(m_hi, m_lo);
        chk("R3 fall loads", 32'(dac_code_o), 32'h089);
        tick(1'b1, 2'd0, 8'hE0, 4'h0);
        tick(1'b1, 2'd1, 8'h33, 4'h0);
        strobe_i = 1'b1;
        idle(); idle(); idle(); m_latch = map_word(m_hi, m_lo);
        chk("R3 both rise", 32'(dac_code_o), 32'h0CD);
        tick(1'b1, 2'd1, 8'h44, 4'h0);
        strobe_i = 1'b0;
        idle(); idle(); idle(); m_latch = map_word(m_hi, m_lo);
        chk("R3 both fall", 32'(dac_code_o), 32'h111);

        // R9 retain across system reset, R8 clears without it
        tick(1'b1, 2'd0, 8'h88, 4'h0);
        tick(1'b0, 2'd0, 8'h00, 4'h1);
        sys_reset();
        check_all("R9 retain sys reset");
        chk("R9 code kept", 32'(dac_code_o), 32'h111);
        por_reset();
        check_all("R9 por clears");
        tick(1'b1, 2'd0, 8'h83, 4'h0);
        tick(1'b1, 2'd1, 8'h55, 4'h0);
        tick(1'b0, 2'd0, 8'h00, 4'h1);
        sys_reset();
        check_all("R8 sys reset clears");

        // random traffic in timer and immediate modes
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            logic [7:0] d;
            logic [1:0] a;
            logic [2:0] md;
            r = $urandom;
            a = 2'(r[1:0] % 3);
            d = 8'($urandom);
            if (a == 2'd0) begin
                md = r[4] ? 3'd7 : {1'b0, r[6:5]};
                d = {d[7], md, d[3:0]};
            end
            tick(r[8] | r[9], a, d, (r[12:10] == 3'd0) ? 4'(r[16:13]) : 4'h0);
            check_all("R2 R4 R7 random");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule